// File: doc/BRIEF.md
# On-Off Threshold Backpressure Controller

This block implements hysteresis-based backpressure on one link between two routers. On the receiving side it tracks the number of free flit slots in an input buffer. It raises a stop message only when free space falls below a low mark. It raises a go message only when free space climbs above a higher mark. Because messages are sent only when the state changes, and not for every flit, far fewer control messages cross the link than a per-flit credit return would need.

A parameterized delay line models the time a message takes to cross the link and be processed. At the far end, a sending-side gate opens or closes a transmit permission. The low mark has to leave room for every flit that is already launched before the stop takes effect. The high mark has to keep enough flits buffered that the receiver does not run dry while the go message travels back. Both rules, and the ordering of the marks, are checked when the design is elaborated.

Receiving-side states: `RX_FLOW` (accepting, last message was go) and `RX_HALT` (last message was stop). Transition `RX_FLOW -> RX_HALT` fires when the next free count is below `OFF_TH`. Transition `RX_HALT -> RX_FLOW` fires when the next free count is above `ON_TH`. Sending-side states: `TX_GO` (transmit permitted) and `TX_WAIT` (transmit withheld). A delayed stop message moves the gate to `TX_WAIT`, and a delayed go message moves it to `TX_GO`.

Top module: `onoff_backpressure`

## Requirements
- R1: After reset, `free_slots` equals `DEPTH`, `tx_enable` is 1, `sig_valid` is 0, `overflow_err` is 0, and both state machines are in `RX_FLOW` and `TX_GO`.
- R2: One cycle after an edge that samples `buf_push` alone, `free_slots` is one lower. One cycle after an edge that samples `buf_pop` alone, it is one higher. With both sampled, it is unchanged.
- R3: A `buf_pop` while `free_slots` equals `DEPTH` is ignored, and the count stays at `DEPTH`.
- R4: In `RX_FLOW`, when the updated free count is below `OFF_TH`, `sig_valid` is 1 with `sig_on` = 0 for exactly one cycle. This happens in the same cycle the new count appears.
- R5: In `RX_HALT`, when the updated free count is above `ON_TH`, `sig_valid` is 1 with `sig_on` = 1 for exactly one cycle. This happens in the same cycle the new count appears.
- R6: `sig_valid` is 0 in every other cycle. In particular, counts that move between the marks send nothing, and no two consecutive cycles both carry a message.
- R7: A message shown on `sig_valid` in cycle t sets `tx_enable` in cycle t+SIG_DELAY+1. A stop message sets it to 0, and a go message sets it to 1.
- R8: `tx_enable` changes only in response to a delayed message. Otherwise it holds its value.
- R9: A `buf_push` without an accepted `buf_pop` while `free_slots` is 0 sets `overflow_err`. The count stays at 0, and `overflow_err` stays at 1 until reset.
- R10: Elaboration requires `ON_TH > OFF_TH`, `OFF_TH-1 >= RT` and `DEPTH-ON_TH-1 >= RT`, where RT = SIG_DELAY+1+FLIT_LAT. With these marks, a sender that pushes every cycle while it sees `tx_enable` (one cycle late) never fills the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_push | input | 1 | A flit is written into the receive buffer this cycle |
| buf_pop | input | 1 | A flit leaves the receive buffer this cycle |
| free_slots | output | $clog2(DEPTH+1) | Current number of free buffer slots |
| sig_valid | output | 1 | A backpressure message is sent this cycle |
| sig_on | output | 1 | Message kind: 1 = go, 0 = stop |
| tx_enable | output | 1 | Sending-side permission after link and processing delay |
| overflow_err | output | 1 | Sticky: a flit arrived with no free slot |

## Verification
The assertions assume that `buf_push` and `buf_pop` are single-cycle-sampled levels with no other protocol. They also assume the parameters meet the R10 checks, so that a message can never follow another in the next cycle. The bench drives only these two inputs, at falling clock edges, one step per cycle. It deliberately includes pops on an empty buffer, pushes into a full buffer, and simultaneous push and pop. This exercises the ignore, overflow and stable-count paths without breaking the assumptions. One phase behaves as a compliant sender, pushing only on the `tx_enable` it saw in the previous cycle. This phase shows that in-flight flits are absorbed.

// File: rtl/onoff_pkg.sv
package onoff_pkg;

    typedef enum logic {
        RX_FLOW = 1'b0,
        RX_HALT = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_GO   = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic valid;
        logic on;
    } flow_msg_t;

endpackage

// File: rtl/onoff_rx_watch.sv
module onoff_rx_watch
    import onoff_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int OFF_TH = 6,
    parameter int ON_TH  = 10,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [CW-1:0] free_o,
    output flow_msg_t     msg_o,
    output logic          overflow_o
);

    localparam logic [CW-1:0] FULL_FREE = CW'(DEPTH);
    localparam logic [CW-1:0] LOW_MARK  = CW'(OFF_TH);
    localparam logic [CW-1:0] HIGH_MARK = CW'(ON_TH);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] free_d;
    logic          pop_ok, push_lost, push_ok;
    flow_msg_t     msg_d;

    // Count update: pops on an empty buffer are dropped, pushes into a full one are lost.
    always_comb begin
        pop_ok    = pop_i && (free_o != FULL_FREE);
        push_lost = push_i && (free_o == '0) && !pop_ok;
        push_ok   = push_i && !push_lost;
        free_d    = free_o + CW'(pop_ok) - CW'(push_ok);
    end

    // Next state and message: sent only on a transition.
    always_comb begin
        state_d = state_q;
        msg_d   = '0;
        unique case (state_q)
            RX_FLOW: if (free_d < LOW_MARK) begin
                state_d   = RX_HALT;
                msg_d.valid = 1'b1;
                msg_d.on    = 1'b0;
            end
            RX_HALT: if (free_d > HIGH_MARK) begin
                state_d   = RX_FLOW;
                msg_d.valid = 1'b1;
                msg_d.on    = 1'b1;
            end
            default: state_d = RX_FLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_FLOW;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_o     <= FULL_FREE;
            msg_o      <= '0;
            overflow_o <= 1'b0;
        end else begin
            free_o     <= free_d;
            msg_o      <= msg_d;
            overflow_o <= overflow_o | push_lost;
        end
    end

    // R2: the count never leaves its range
    p_free_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_o <= FULL_FREE);
    // R4: a stop message coincides with a count below the low mark
    p_off_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_o.valid && !msg_o.on) |-> (free_o < LOW_MARK));
    // R5: a go message coincides with a count above the high mark
    p_on_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_o.valid && msg_o.on) |-> (free_o > HIGH_MARK));
    // R6: never two messages back to back
    p_single_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o.valid |=> !msg_o.valid);
    // R9: the overflow flag is sticky
    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    // R3: a pop on an empty buffer leaves the count at full
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o == FULL_FREE && pop_i && !push_i) |=> (free_o == FULL_FREE));

endmodule

// File: rtl/onoff_sig_pipe.sv
module onoff_sig_pipe
    import onoff_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  flow_msg_t msg_i,
    output flow_msg_t msg_o
);

    localparam int MW = $bits(flow_msg_t);

    if (STAGES == 1) begin : g_one
        flow_msg_t held_q;
        always_ff @(posedge clk) begin
            if (!rst_n) held_q <= '0;
            else        held_q <= msg_i;
        end
        assign msg_o = held_q;
    end else begin : g_chain
        logic [STAGES*MW-1:0] line_q;
        always_ff @(posedge clk) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= {line_q[(STAGES-1)*MW-1:0], msg_i};
        end
        assign msg_o = line_q[STAGES*MW-1 -: MW];
    end

endmodule

// File: rtl/onoff_tx_gate.sv
module onoff_tx_gate
    import onoff_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flow_msg_t msg_i,
    output logic      tx_enable_o
);

    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_GO:   if (msg_i.valid && !msg_i.on) state_d = TX_WAIT;
            TX_WAIT: if (msg_i.valid &&  msg_i.on) state_d = TX_GO;
            default: state_d = TX_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_GO;
        else        state_q <= state_d;
    end

    always_comb tx_enable_o = (state_q == TX_GO);

    // R8: without an arriving message the permission holds
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_i.valid |=> $stable(tx_enable_o));
    // R7: an arriving stop closes the gate on the next edge
    p_gate_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_i.valid && !msg_i.on) |=> !tx_enable_o);

endmodule

// File: rtl/onoff_backpressure.sv
module onoff_backpressure
    import onoff_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int OFF_TH    = 6,
    parameter int ON_TH     = 10,
    parameter int SIG_DELAY = 2,
    parameter int FLIT_LAT  = 1,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int RT       = SIG_DELAY + 1 + FLIT_LAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_push,
    input  logic          buf_pop,
    output logic [CW-1:0] free_slots,
    output logic          sig_valid,
    output logic          sig_on,
    output logic          tx_enable,
    output logic          overflow_err
);

    // R10: mark ordering and in-flight margins are enforced at elaboration
    if (SIG_DELAY < 1 || ON_TH <= OFF_TH || (OFF_TH - 1) < RT
        || (DEPTH - ON_TH - 1) < RT) begin : g_bad_marks
        $error("onoff_backpressure: thresholds do not cover the round trip");
    end

    flow_msg_t rx_msg, far_msg;

    onoff_rx_watch #(
        .DEPTH  (DEPTH),
        .OFF_TH (OFF_TH),
        .ON_TH  (ON_TH)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (buf_push),
        .pop_i      (buf_pop),
        .free_o     (free_slots),
        .msg_o      (rx_msg),
        .overflow_o (overflow_err)
    );

    onoff_sig_pipe #(
        .STAGES (SIG_DELAY)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .msg_i (rx_msg),
        .msg_o (far_msg)
    );

    onoff_tx_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .msg_i       (far_msg),
        .tx_enable_o (tx_enable)
    );

    assign sig_valid = rx_msg.valid;
    assign sig_on    = rx_msg.on;

endmodule

// File: tb/onoff_backpressure_tb.sv
`timescale 1ns/100ps
module onoff_backpressure_tb;

    localparam int DEPTH = 16, OFF_TH = 6, ON_TH = 10, SIG_DELAY = 2, FLIT_LAT = 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0, buf_push = 1'b0, buf_pop = 1'b0;
    logic [CW-1:0] free_slots;
    logic sig_valid, sig_on, tx_enable, overflow_err;

    onoff_backpressure #(
        .DEPTH(DEPTH), .OFF_TH(OFF_TH), .ON_TH(ON_TH),
        .SIG_DELAY(SIG_DELAY), .FLIT_LAT(FLIT_LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .buf_push(buf_push), .buf_pop(buf_pop),
        .free_slots(free_slots), .sig_valid(sig_valid), .sig_on(sig_on),
        .tx_enable(tx_enable), .overflow_err(overflow_err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    tgt;
        int    fld;
        int    val;
        string req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    int   m_free = DEPTH;
    bit   m_halt = 1'b0, m_tx = 1'b1, m_ovf = 1'b0;
    int   hv[int];
    int   hon[int];

    function automatic void check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endfunction

    function automatic int observe(int fld);
        case (fld)
            0:       return int'(free_slots);
            1:       return int'(sig_valid);
            2:       return int'(sig_on);
            3:       return int'(tx_enable);
            default: return int'(overflow_err);
        endcase
    endfunction

    function automatic string fname(int fld);
        case (fld)
            0:       return "free_slots";
            1:       return "sig_valid";
            2:       return "sig_on";
            3:       return "tx_enable";
            default: return "overflow_err";
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(input bit p, input bit q);
        int  t;
        bit  pe, ov;
        int  v, on;
        bit  tx_old;
        exp_t e;
        @(negedge clk);
        buf_push = p;
        buf_pop  = q;
        t  = cyc + 1;
        pe = q && (m_free < DEPTH);
        ov = p && (m_free == 0) && !pe;
        m_free = m_free + int'(pe) - int'(p && !ov);
        if (ov) m_ovf = 1'b1;
        v = 0; on = 0;
        if (!m_halt && m_free < OFF_TH) begin
            m_halt = 1'b1; v = 1; on = 0;
        end else if (m_halt && m_free > ON_TH) begin
            m_halt = 1'b0; v = 1; on = 1;
        end
        hv[t] = v; hon[t] = on;
        tx_old = m_tx;
        if (hv.exists(t - SIG_DELAY - 1) && hv[t - SIG_DELAY - 1] == 1)
            m_tx = (hon[t - SIG_DELAY - 1] == 1);
        e.tgt = t;
        e.fld = 0; e.val = m_free;
        e.req = ov ? "R9" : ((q && !pe) ? "R3" : "R2");
        sb.push_back(e);
        e.fld = 1; e.val = v; e.req = (v == 0) ? "R6" : (on == 1 ? "R5" : "R4");
        sb.push_back(e);
        if (v == 1) begin
            e.fld = 2; e.val = on; e.req = (on == 1) ? "R5" : "R4";
            sb.push_back(e);
        end
        e.fld = 3; e.val = int'(m_tx); e.req = (tx_old != m_tx) ? "R7" : "R8";
        sb.push_back(e);
        e.fld = 4; e.val = int'(m_ovf); e.req = "R9";
        sb.push_back(e);
    endtask

    // Monitor: pops expectations due this cycle and compares them.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].tgt <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, fname(e.fld), observe(e.fld), e.val);
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check("R1", "free_slots", int'(free_slots), DEPTH);
        check("R1", "tx_enable", int'(tx_enable), 1);
        check("R1", "sig_valid", int'(sig_valid), 0);
        check("R1", "overflow_err", int'(overflow_err), 0);

        // R3: pops on an empty buffer
        step(0, 1); step(0, 1);
        // R2: single push, single pop, both together
        step(1, 0); step(0, 1); step(1, 0); step(1, 1); step(0, 1);

        // R4: fill until the stop message, then in-flight pushes
        repeat (11) step(1, 0);
        repeat (3) step(1, 0);
        repeat (4) step(0, 0);

        // R6: wander between the marks while halted
        repeat (4) step(0, 1);
        repeat (2) step(1, 0);
        repeat (5) step(0, 1);
        step(0, 1);
        // R5: cross the high mark
        step(0, 1);
        repeat (4) step(0, 0);

        // R6: wander between the marks while flowing, then R4 again
        repeat (5) step(1, 0);
        repeat (3) step(0, 1);
        repeat (3) step(1, 0);
        step(1, 0);
        repeat (4) step(0, 0);

        // Drain to empty (R5, R7)
        repeat (12) step(0, 1);
        repeat (4) step(0, 0);

        // R10: compliant sender pushes on the permission it saw one cycle earlier
        repeat (24) step(tx_enable, 1'b0);
        repeat (4) step(0, 0);
        @(negedge clk); #1;
        check("R10", "overflow_err", int'(overflow_err), 0);
        check("R10", "free_slots>0", int'(free_slots > 0), 1);
        repeat (20) step(0, 1);
        repeat (4) step(0, 0);

        // R9: fill completely, then push into a full buffer
        repeat (DEPTH) step(1, 0);
        step(1, 0);
        step(1, 1);
        step(0, 0);
        step(0, 1);
        repeat (4) step(0, 0);
        @(negedge clk); #1;
        check("R9", "overflow_err sticky", int'(overflow_err), 1);

        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule